// File: doc/BRIEF.md
# ASCII Command Line Decoder

This block sits behind a serial byte receiver and turns short text lines into bus requests. Each incoming byte arrives with a one-cycle valid strobe. The decoder follows a strict line grammar. A read line is the letter `R`, then an address in hex. A write line is the letter `W`, then an address and a data word in hex. When a well-formed line ends, the decoder emits one request carrying a direction flag, a 16-bit address and a 16-bit data word.

Any line that breaks the grammar is thrown away and never reaches the bus. This covers a wrong command letter, a wrong digit count and a character outside the digit set. After such a line, the parser waits for the next carriage return or line feed and then looks for a fresh command letter. The byte input never stalls: `in_ready` is held high, so every byte offered with `in_valid` is consumed on that edge. The request output has no ready signal, and the bus side must take each pulse when it appears.

Top module: `cmd_line_decoder`

## Requirements
- R1: A line made of `R` (0x52), exactly four hex digits and a terminator produces one request with `req_write`=0. `req_addr` holds the four digits, with the first digit received as the most significant nibble, and `req_data` is 0.
- R2: A line made of `W` (0x57), exactly eight hex digits and a terminator produces one request with `req_write`=1. The first four digits form `req_addr` and the last four form `req_data`; in each, the earlier digit is the more significant nibble.
- R3: A line ends with CR (0x0D), LF (0x0A) or CR followed by LF. The LF of a CR-LF pair, and any blank line, produces nothing.
- R4: The only valid digits are `0`-`9` (0x30-0x39) and uppercase `A`-`F` (0x41-0x46). A line with a lowercase letter among its digits is rejected.
- R5: A line with fewer or more digits than its command needs produces no request. This includes `R` directly followed by a terminator.
- R6: A line with a non-digit character among or after its digits produces no request.
- R7: A line whose first byte is neither `R` nor `W` produces no request. This includes a lowercase `r` or `w`. After any rejected line, the next CR or LF returns the parser to waiting for a command, and the line that follows decodes normally.
- R8: `req_valid` rises on the clock edge that accepts the terminator byte and stays high for exactly one cycle. `req_write`, `req_addr` and `req_data` are valid with it and hold their values until the next request.
- R9: `in_ready` is always 1. A byte presented with `in_valid` low is ignored, even when it is a terminator, and any number of idle cycles may separate bytes.
- R10: While `rst` is high, and in the cycle after it, `req_valid` is 0. Reset also clears `req_write`, `req_addr` and `req_data` to 0 and puts the parser in the waiting-for-command state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe, high for each received byte |
| in_ready | output | 1 | Constant 1; the decoder never holds off the byte stream |
| in_data | input | 8 | Received ASCII byte |
| req_valid | output | 1 | One-cycle request pulse |
| req_write | output | 1 | 1 for a write request, 0 for a read |
| req_addr | output | 16 | Request address |
| req_data | output | 16 | Write data; 0 for reads |

## Verification
The checker relies on `in_valid` and `in_data` being known whenever reset is low. It also relies on every request being preceded by at least a command letter and some digits, which keeps two pulses from landing on adjacent cycles. The driver changes inputs only on the falling clock edge and keeps `in_valid` high for a single cycle per byte. While the strobe is low, it parks `in_data` on the CR code, so the stimulus holds to these assumptions and also exercises the rule that unstrobed bytes are ignored. A scoreboard queue holds the requests the grammar predicts. The monitor flags any pulse that arrives with the queue empty, and this is how silently dropped lines are proven to stay silent.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_LF   = 8'h0A;
  localparam logic [7:0] CH_RD   = 8'h52;
  localparam logic [7:0] CH_WR   = 8'h57;
  localparam logic [7:0] CH_ZERO = 8'h30;
  localparam logic [7:0] CH_NINE = 8'h39;
  localparam logic [7:0] CH_UA   = 8'h41;
  localparam logic [7:0] CH_UF   = 8'h46;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_DIGITS,
    PS_TERM,
    PS_SKIP
  } parse_state_t;

  typedef struct packed {
    logic       is_hex;
    logic       is_term;
    logic       is_rd;
    logic       is_wr;
    logic [3:0] nib;
  } char_class_t;

endpackage

// File: rtl/cmd_char_class.sv
module cmd_char_class
  import cmd_dec_pkg::*;
(
  input  logic [7:0]  ch,
  output char_class_t cls
);

  logic       dec_dig;
  logic       hex_let;
  logic [7:0] dec_off;
  logic [7:0] let_off;

  always_comb begin
    dec_dig = (ch >= CH_ZERO) && (ch <= CH_NINE);
    hex_let = (ch >= CH_UA) && (ch <= CH_UF);
    dec_off = ch - CH_ZERO;
    let_off = ch - CH_UA + 8'd10;

    cls.is_hex  = dec_dig || hex_let;
    cls.is_term = (ch == CH_CR) || (ch == CH_LF);
    cls.is_rd   = (ch == CH_RD);
    cls.is_wr   = (ch == CH_WR);
    cls.nib     = dec_dig ? dec_off[3:0] : let_off[3:0];
  end

endmodule

// File: rtl/cmd_frame_fsm.sv
module cmd_frame_fsm
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_NIB = 4,
  parameter int DATA_NIB = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  input  char_class_t cls,
  output logic        start,
  output logic        shift_en,
  output logic        fire,
  output logic        fire_write
);

  localparam int TOTAL_NIB = ADDR_NIB + DATA_NIB;
  localparam int CNT_W     = $clog2(TOTAL_NIB + 1);

  localparam logic [CNT_W-1:0] NEED_RD = CNT_W'(ADDR_NIB);
  localparam logic [CNT_W-1:0] NEED_WR = CNT_W'(TOTAL_NIB);

  parse_state_t     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] cnt_inc;

  assign need    = wr_q ? NEED_WR : NEED_RD;
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    wr_d       = wr_q;
    start      = 1'b0;
    shift_en   = 1'b0;
    fire       = 1'b0;
    fire_write = wr_q;

    if (step) begin
      unique case (state_q)
        PS_IDLE: begin
          if (cls.is_rd || cls.is_wr) begin
            start   = 1'b1;
            wr_d    = cls.is_wr;
            cnt_d   = '0;
            state_d = PS_DIGITS;
          end else if (!cls.is_term) begin
            state_d = PS_SKIP;
          end
        end
        PS_DIGITS: begin
          if (cls.is_hex) begin
            shift_en = 1'b1;
            cnt_d    = cnt_inc;
            if (cnt_inc == need) begin
              state_d = PS_TERM;
            end
          end else if (cls.is_term) begin
            state_d = PS_IDLE;
          end else begin
            state_d = PS_SKIP;
          end
        end
        PS_TERM: begin
          if (cls.is_term) begin
            fire    = 1'b1;
            state_d = PS_IDLE;
          end else begin
            state_d = PS_SKIP;
          end
        end
        PS_SKIP: begin
          if (cls.is_term) begin
            state_d = PS_IDLE;
          end
        end
        default: state_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

endmodule

// File: rtl/cmd_field_shift.sv
module cmd_field_shift #(
  parameter int NIB = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             shift_en,
  input  logic [3:0]       nib_in,
  output logic [4*NIB-1:0] field
);

  localparam int W = 4 * NIB;

  logic [W-1:0] sh_q;

  generate
    if (NIB == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || clear) sh_q <= '0;
        else if (shift_en) sh_q <= nib_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst || clear) sh_q <= '0;
        else if (shift_en) sh_q <= {sh_q[W-5:0], nib_in};
      end
    end
  endgenerate

  assign field = sh_q;

endmodule

// File: rtl/cmd_line_decoder.sv
module cmd_line_decoder
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);

  localparam int ADDR_NIB  = ADDR_W / 4;
  localparam int DATA_NIB  = DATA_W / 4;
  localparam int TOTAL_NIB = ADDR_NIB + DATA_NIB;
  localparam int FIELD_W   = 4 * TOTAL_NIB;

  char_class_t        cls;
  logic               start;
  logic               shift_en;
  logic               fire;
  logic               fire_write;
  logic [FIELD_W-1:0] field;

  assign in_ready = 1'b1;

  cmd_char_class u_class (
    .ch  (in_data),
    .cls (cls)
  );

  cmd_frame_fsm #(
    .ADDR_NIB (ADDR_NIB),
    .DATA_NIB (DATA_NIB)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .step       (in_valid),
    .cls        (cls),
    .start      (start),
    .shift_en   (shift_en),
    .fire       (fire),
    .fire_write (fire_write)
  );

  cmd_field_shift #(
    .NIB (TOTAL_NIB)
  ) u_field (
    .clk      (clk),
    .rst      (rst),
    .clear    (start),
    .shift_en (shift_en),
    .nib_in   (cls.nib),
    .field    (field)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= fire;
      if (fire) begin
        req_write <= fire_write;
        if (fire_write) begin
          req_addr <= field[FIELD_W-1 -: ADDR_W];
          req_data <= field[DATA_W-1:0];
        end else begin
          req_addr <= field[ADDR_W-1:0];
          req_data <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/cmd_line_decoder_chk.sv
module cmd_line_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        in_data,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data
);

  a_r8_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  a_r3_fire_on_terminator: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(in_valid && (in_data == 8'h0D || in_data == 8'h0A)));

  a_r1_read_data_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |-> (req_data == '0));

  a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> ($stable(req_addr) && $stable(req_data) && $stable(req_write)));

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> !req_valid);

endmodule

bind cmd_line_decoder cmd_line_decoder_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_data  (req_data)
);

// File: tb/cmd_line_decoder_test.sv
module cmd_line_decoder_test;

  localparam int T_CR = 1;
  localparam int T_LF = 2;
  localparam int T_CRLF = 0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h0D;
  logic        req_valid;
  logic        req_write;
  logic [15:0] req_addr;
  logic [15:0] req_data;

  int checks = 0;
  int fails = 0;
  int gap = 0;
  string phase = "R10";
  logic prev_valid = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cmd_line_decoder uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_data  (req_data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_req(input bit wr, input logic [15:0] a,
                            input logic [15:0] d, input string tag);
    exp_q.push_back({wr, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 8'h0D;
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_line(input string body, input int term);
    for (int i = 0; i < body.len(); i++) send_byte(body[i]);
    if (term == T_CRLF || term == T_CR) send_byte(8'h0D);
    if (term == T_CRLF || term == T_LF) send_byte(8'h0A);
  endtask

  task automatic drain(input string tag);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, tag, "pending requests", exp_q.size(), 0);
  endtask

  // Monitor: compare each pulse against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (req_valid) begin
        if (prev_valid)
          check(1'b0, "R8", "pulse longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, phase, "unexpected request",
                {31'd0, req_write, req_addr, req_data}, 0);
        end else begin
          logic [32:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({req_write, req_addr, req_data} == e, t, "request",
                {req_write, req_addr, req_data}, e);
        end
      end
      prev_valid = req_valid;
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    check({req_valid, req_write, req_addr, req_data} == 34'd0, "R10",
          "outputs in reset", {req_valid, req_write, req_addr, req_data}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(req_valid == 1'b0, "R10", "valid after reset", req_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready", in_ready, 1);

    phase = "R1";
    expect_req(1'b0, 16'h0000, 16'h0000, "R1");
    send_line("R0000", T_CRLF);
    expect_req(1'b0, 16'h7C3F, 16'h0000, "R1");
    send_line("R7C3F", T_CRLF);
    expect_req(1'b0, 16'hFFFF, 16'h0000, "R1");
    send_line("RFFFF", T_CRLF);
    drain("R1");

    phase = "R2";
    expect_req(1'b1, 16'hA5E1, 16'h0F9D, "R2");
    send_line("WA5E10F9D", T_CRLF);
    expect_req(1'b1, 16'h0001, 16'hBEC0, "R2");
    send_line("W0001BEC0", T_LF);
    drain("R2");

    phase = "R3";
    send_line("", T_LF);
    send_line("", T_CRLF);
    expect_req(1'b0, 16'h2468, 16'h0000, "R3");
    send_line("R2468", T_CR);
    expect_req(1'b1, 16'h1357, 16'h9ACE, "R3");
    send_line("W13579ACE", T_LF);
    expect_req(1'b0, 16'hD00D, 16'h0000, "R3");
    send_line("RD00D", T_CRLF);
    drain("R3");

    phase = "R4";
    send_line("R00a0", T_CRLF);
    send_line("W1234abcd", T_CRLF);
    expect_req(1'b0, 16'h9ABC, 16'h0000, "R4");
    send_line("R9ABC", T_CRLF);
    drain("R4");

    phase = "R5";
    send_line("R123", T_CRLF);
    send_line("R12345", T_CRLF);
    send_line("W1234567", T_CR);
    send_line("W123456789AB", T_LF);
    send_line("R", T_CRLF);
    expect_req(1'b0, 16'h5A5A, 16'h0000, "R5");
    send_line("R5A5A", T_CRLF);
    drain("R5");

    phase = "R6";
    send_line("R12G4", T_CRLF);
    send_line("W12[4ABCD", T_CRLF);
    send_line("R1234 ", T_CRLF);
    send_line("WAB()##*@", T_LF);
    expect_req(1'b1, 16'hCAFE, 16'h0042, "R6");
    send_line("WCAFE0042", T_CRLF);
    drain("R6");

    phase = "R7";
    send_line("M", T_CRLF);
    send_line("r1234", T_CRLF);
    send_line("X12345678", T_LF);
    send_line("QR1234", T_CR);
    expect_req(1'b0, 16'h3C3C, 16'h0000, "R7");
    send_line("R3C3C", T_CRLF);
    drain("R7");

    phase = "R8";
    expect_req(1'b1, 16'h8421, 16'h1248, "R8");
    send_line("W84211248", T_CR);
    drain("R8");
    repeat (10) @(negedge clk);
    check({req_write, req_addr, req_data} == {1'b1, 16'h8421, 16'h1248}, "R8",
          "held outputs", {req_write, req_addr, req_data}, {1'b1, 16'h8421, 16'h1248});

    phase = "R9";
    gap = 3;
    expect_req(1'b1, 16'hF00F, 16'h7007, "R9");
    send_line("WF00F7007", T_CRLF);
    expect_req(1'b0, 16'h0E1D, 16'h0000, "R9");
    send_line("R0E1D", T_LF);
    gap = 0;
    drain("R9");
    check(in_ready == 1'b1, "R9", "in_ready after traffic", in_ready, 1);
  endtask

  initial begin
    bit timed_out = 1'b0;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (200000) @(negedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "R9", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule